// File: doc/BRIEF.md
# Constant-Time Secret Comparator

This block decides whether a submitted guess equals a stored secret of `LEN` bytes, for example a PIN or an authentication tag. On an accepted start it captures both operands into per-byte register lanes, then walks a byte counter across every lane. Each cycle takes the XOR of one guess byte and its secret byte and ORs that difference into a sticky accumulator. The scan never stops early.

A single verdict is produced only after the last byte has been folded in. The completion pulse always arrives the same number of cycles after start, whatever the operands hold. This means neither the latency nor the sequence of internal steps tells an observer how many leading bytes were correct. The verdict stays on the output until the next accepted start.

Top module: `ctc_compare`

## Requirements
- R1: After reset, busy_o, done_o and match_o are all 0.
- R2: A start_i sampled high while busy_o is 0 is accepted. From the next cycle, busy_o is 1 and match_o is 0 for the whole scan.
- R3: done_o is high for exactly one cycle, `LEN` clock edges after the accepting edge. In that same cycle busy_o has returned to 0.
- R4: Byte k of each operand is bits [8k+7:8k]. match_o becomes 1 with done_o exactly when every guess byte equals the secret byte at the same position.
- R5: A difference in any byte or bit position, first or last or several, gives match_o = 0 with the same latency as an equal pair.
- R6: A start_i sampled while busy_o is 1 is ignored. The scan in progress keeps its timing and its verdict.
- R7: Once done_o has pulsed, match_o holds its value until the next accepted start.
- R8: The operands are captured on the accepting edge. Changes to guess_i or secret_i during the scan do not change the verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a comparison |
| guess_i | input | LEN*8 | Submitted value, byte k at [8k+7:8k] |
| secret_i | input | LEN*8 | Reference value, same byte layout |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| match_o | output | 1 | Registered verdict, 1 = equal |

## Verification
The bench measures completion latency for pairs that differ only in the first byte, only in the last byte, in a single middle bit, or everywhere, and requires all of them to match the latency of an equal pair. A design that exits early would show a shorter count for a leading mismatch. It also pulses start in the middle of a scan and rewrites the operands at the same time. A design that restarts or samples the ports live would shift done_o or report the wrong verdict. Finally, it idles after completion and checks that the verdict neither decays nor survives into the next scan.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } ctc_state_e;
endpackage

// File: rtl/ctc_lane.sv
module ctc_lane
  import ctc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] guess_i,
  input  logic [BYTE_W-1:0] secret_i,
  output logic [BYTE_W-1:0] diff_o
);
  logic [BYTE_W-1:0] guess_q;
  logic [BYTE_W-1:0] secret_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      guess_q  <= '0;
      secret_q <= '0;
    end else if (load_i) begin
      guess_q  <= guess_i;
      secret_q <= secret_i;
    end
  end

  assign diff_o = guess_q ^ secret_q;
endmodule

// File: rtl/ctc_seq.sv
module ctc_seq
  import ctc_pkg::*;
#(
  parameter int unsigned LEN   = 8,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             accept_o,
  output logic             scan_o,
  output logic             last_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LEN - 1);

  ctc_state_e      state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;

  assign scan_o   = (state_q == ST_SCAN);
  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign last_o   = scan_o && (idx_q == LAST_IDX);
  assign idx_o    = idx_q;
  assign done_o   = done_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SCAN;
          idx_d   = '0;
        end
      end
      ST_SCAN: begin
        // step count is fixed; the data never steers this
        if (idx_q == LAST_IDX) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/ctc_fold.sv
module ctc_fold
  import ctc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic              last_i,
  input  logic [BYTE_W-1:0] diff_i,
  output logic              match_o
);
  logic [BYTE_W-1:0] acc_q;
  logic [BYTE_W-1:0] acc_next;
  logic              match_q;

  assign acc_next = acc_q | diff_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      match_q <= 1'b0;
    end else if (clear_i) begin
      acc_q   <= '0;
      match_q <= 1'b0;
    end else if (step_i) begin
      acc_q <= acc_next;
      if (last_i) match_q <= (acc_next == '0);
    end
  end

  assign match_o = match_q;
endmodule

// File: rtl/ctc_compare.sv
module ctc_compare
  import ctc_pkg::*;
#(
  parameter int unsigned LEN = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [LEN*BYTE_W-1:0] guess_i,
  input  logic [LEN*BYTE_W-1:0] secret_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  match_o
);
  localparam int unsigned CNT_W = (LEN > 1) ? $clog2(LEN) : 1;

  logic             accept;
  logic             scan;
  logic             last;
  logic [CNT_W-1:0] idx;
  logic [BYTE_W-1:0] diff_lane [LEN];
  logic [BYTE_W-1:0] diff_sel;

  ctc_seq #(.LEN(LEN), .CNT_W(CNT_W)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .scan_o   (scan),
    .last_o   (last),
    .idx_o    (idx),
    .done_o   (done_o)
  );

  for (genvar k = 0; k < LEN; k++) begin : g_lane
    ctc_lane i_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (accept),
      .guess_i  (guess_i[k*BYTE_W +: BYTE_W]),
      .secret_i (secret_i[k*BYTE_W +: BYTE_W]),
      .diff_o   (diff_lane[k])
    );
  end

  always_comb begin
    diff_sel = '0;
    for (int k = 0; k < LEN; k++) begin
      if (idx == CNT_W'(k)) diff_sel = diff_lane[k];
    end
  end

  ctc_fold i_fold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .step_i  (scan),
    .last_i  (last),
    .diff_i  (diff_sel),
    .match_o (match_o)
  );

  assign busy_o = scan;
endmodule

// File: rtl/ctc_compare_chk.sv
module ctc_compare_chk #(
  parameter int unsigned LEN = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic match_o
);
  localparam int unsigned W = $clog2(LEN + 2) + 1;
  logic [W-1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_q <= '0;
    else if (start_i && !busy_o) since_q <= '0;
    else if (busy_o) since_q <= since_q + 1'b1;
  end

  a_r2_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !match_o));

  a_r2_match_low_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !match_o);

  a_r3_done_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (since_q == W'(LEN)));

  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r3_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r7_match_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(match_o));
endmodule

bind ctc_compare ctc_compare_chk #(.LEN(LEN)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .match_o (match_o)
);

// File: tb/test_ctc_compare.sv
module test_ctc_compare;
  localparam int LEN = 8;
  localparam int VW  = LEN * 8;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [VW-1:0] guess = '0;
  logic [VW-1:0] secret = '0;
  logic          busy, done, match;

  int checks = 0;
  int errors = 0;
  int wd = 0;

  // reference model state
  bit  m_busy, m_done, m_match;
  int  m_cnt;
  int  m_acc;
  byte unsigned m_g[LEN];
  byte unsigned m_s[LEN];

  ctc_compare #(.LEN(LEN)) i_ctc_compare (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .guess_i  (guess),
    .secret_i (secret),
    .busy_o   (busy),
    .done_o   (done),
    .match_o  (match)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_match = 0; m_cnt = 0; m_acc = 0;
    end else if (m_busy) begin
      m_done = 0;
      m_acc = m_acc | (m_g[m_cnt] ^ m_s[m_cnt]);
      if (m_cnt == LEN - 1) begin
        m_busy = 0; m_done = 1; m_match = (m_acc == 0);
      end else m_cnt++;
    end else begin
      m_done = 0;
      if (start) begin
        for (int k = 0; k < LEN; k++) begin
          m_g[k] = guess[k*8 +: 8];
          m_s[k] = secret[k*8 +: 8];
        end
        m_busy = 1; m_cnt = 0; m_acc = 0; m_match = 0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 busy vs model", busy, m_busy);
      chk("R3 done vs model", done, m_done);
      chk("R4 match vs model", match, m_match);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // launch one comparison, return verdict and edges from accept to done
  task automatic run(input logic [VW-1:0] g, input logic [VW-1:0] s,
                     output int lat, output bit res);
    @(negedge clk);
    guess = g; secret = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    res = match;
  endtask

  function automatic logic [VW-1:0] pat(input int seed);
    logic [VW-1:0] v;
    for (int k = 0; k < LEN; k++) v[k*8 +: 8] = 8'((seed * 37 + k * 101 + 13) & 8'hff);
    return v;
  endfunction

  initial begin
    int lat;
    bit res;
    logic [VW-1:0] a, b;

    #(CLK_PERIOD * 2.3);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 match", match, 0);
    rst_n = 1'b1;

    a = pat(1);
    run(a, a, lat, res);
    chk("R4 equal verdict", res, 1);
    chk("R3 latency equal", lat, LEN);

    b = a; b[7:0] = b[7:0] ^ 8'h01;
    run(b, a, lat, res);
    chk("R5 first byte differs", res, 0);
    chk("R5 latency first", lat, LEN);

    b = a; b[VW-1 -: 8] = b[VW-1 -: 8] ^ 8'h80;
    run(b, a, lat, res);
    chk("R5 last byte differs", res, 0);
    chk("R5 latency last", lat, LEN);

    b = a; b[(LEN/2)*8 + 3] = ~b[(LEN/2)*8 + 3];
    run(a, b, lat, res);
    chk("R5 middle bit differs", res, 0);
    chk("R5 latency middle", lat, LEN);

    run(a, ~a, lat, res);
    chk("R5 all differ", res, 0);
    chk("R5 latency all", lat, LEN);

    run('0, '0, lat, res);
    chk("R4 zero equal", res, 1);

    // R7 verdict held while idle
    repeat (5) @(negedge clk);
    chk("R7 match held", match, 1);

    // R6 and R8: start pulse and operand change mid-scan
    b = pat(2);
    @(negedge clk);
    guess = b; secret = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 match low in scan", match, 0);
    chk("R2 busy after accept", busy, 1);
    @(negedge clk);
    guess = '1; secret = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R6 latency unchanged", lat, LEN);
    chk("R8 captured verdict", match, 1);
    @(negedge clk);
    chk("R3 done single cycle", done, 0);
    chk("R6 no restart", busy, 0);

    // continuous start: re-accepted in the idle cycle after done
    a = pat(3); b = a; b[15:8] = ~b[15:8];
    @(negedge clk);
    guess = a; secret = b; start = 1'b1;
    repeat (3 * (LEN + 1)) @(negedge clk);
    start = 1'b0;
    repeat (LEN + 3) @(negedge clk);
    chk("R5 repeated scans verdict", match, 0);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule